// File: doc/BRIEF.md
# Full Processor State Restore Sequencer

This block reloads a complete processor state from a fixed table in memory when a privileged restore command is given. While it runs, it is the bus master of a simple synchronous memory port. It fetches the table one 16-bit word at a time, starting at byte address 0x800 and moving upward. It unpacks each returned word into its destination: the general registers, the instruction pointer, the flags, the machine status word, the segment selectors, the two table-base registers, and the hidden descriptor caches.

Each descriptor cache holds a 24-bit base, an access byte and a 16-bit limit. The caches are written straight from the table. No validity, protection or consistency check is applied, so a cache can describe a segment unrelated to its visible selector, or carry an access byte that a normal segment load would refuse.

A restore requested at a privilege level other than zero is refused. The block raises a fault and touches nothing. A restore at level zero always completes and ends with a one-cycle done pulse. Instruction decode and the use of the restored registers lie outside the block.

Top module: `state_restore_seq`

## Requirements
- R1: When idle, a start request with privilege level 0 sets busy in the next cycle and begins the table fetch.
- R2: Exactly 51 reads are made per restore. Word k is read from byte address 0x800 + 2k, for k = 0 to 50, in ascending order.
- R3: The request and the address are held until ready is high at a clock edge. The read data is taken at that edge. A word with n wait states therefore takes n+1 cycles.
- R4: Table layout by word index:
  - 0 is the status word; 1 to 10 are read and discarded.
  - 11 is the task selector, 12 the flags, 13 the instruction pointer and 14 the local-table selector.
  - 15 to 18 are segment selectors 0 to 3, and 19 to 26 are general registers 0 to 7.
  - 27 to 44 are descriptor caches 0 to 5, three words each. Caches 4 and 5 are the local-table and task caches.
  - 45 to 47 are the global table base and 48 to 50 the interrupt table base.
  - On the selector port, slots 0 to 3 are the segment selectors, slot 4 the local-table selector and slot 5 the task selector.
- R5: Fields are little-endian. In a 3-word entry, word 0 gives base bits 15:0 and the low byte of word 1 gives base bits 23:16. The high byte of word 1 is the access byte in a cache entry and is dropped in a table-base entry. Word 2 is the limit.
- R6: Access bytes, limits and selectors are stored exactly as read, even when an access byte marks the segment not present or a selector does not match its cache.
- R7: A start request at a nonzero privilege level produces a one-cycle fault pulse in the next cycle. It makes no memory request and changes no loaded register.
- R8: Start requests made while busy are ignored. The run still makes exactly 51 reads and no second run follows.
- R9: Done is high for exactly one cycle, in the first cycle in which busy is low after the last read. All restored values are visible in that cycle.
- R10: After reset every output is zero. While idle, the loaded registers hold their values whatever the memory port shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restore command |
| cpl_i | input | 2 | Current privilege level |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 24 | Byte address of the word being read |
| mem_ready_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Restore in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle privilege fault pulse |
| msw_o | output | 16 | Machine status word |
| flags_o | output | 16 | Flags |
| ip_o | output | 16 | Instruction pointer |
| gpr_o | output | 128 | General registers, register g at bits 16g+15:16g |
| sel_o | output | 96 | Selectors, slot s at bits 16s+15:16s |
| cache_base_o | output | 144 | Cache bases, cache c at bits 24c+23:24c |
| cache_acc_o | output | 48 | Cache access bytes, cache c at bits 8c+7:8c |
| cache_lim_o | output | 96 | Cache limits, cache c at bits 16c+15:16c |
| gdt_base_o | output | 24 | Global table base |
| gdt_lim_o | output | 16 | Global table limit |
| idt_base_o | output | 24 | Interrupt table base |
| idt_lim_o | output | 16 | Interrupt table limit |

## Verification
Busy rises one edge after an accepted start. A fault pulse appears one edge after a refused start. Each word is captured on the edge where ready is high, so a run with n wait states keeps busy high for exactly 51(n+1) cycles. Done and the final register values appear together on the edge that captures word 50.

The bench drives inputs and samples outputs on falling edges. It counts busy cycles between the start and the done pulse and compares that count with 51(n+1). It checks done again one cycle later to confirm the pulse is a single cycle. A monitor compares every accepted read address with the next expected address. Decoded fields are compared only after done, against values the bench builds from the table contents using the layout in R4 and R5.

// File: rtl/srs_pkg.sv
package srs_pkg;
   localparam int WORD_W      = 16;
   localparam int BASE_W      = 24;
   localparam int ACC_W       = 8;
   localparam int NUM_GPR     = 8;
   localparam int NUM_SEGSEL  = 4;
   localparam int NUM_SEL     = NUM_SEGSEL + 2;
   localparam int NUM_CACHE   = 6;
   localparam int ENTRY_WORDS = 3;

   localparam int W_MSW    = 0;
   localparam int RSV_WORDS = 10;
   localparam int W_TSEL   = W_MSW + 1 + RSV_WORDS;
   localparam int W_FLAGS  = W_TSEL + 1;
   localparam int W_IP     = W_FLAGS + 1;
   localparam int W_LSEL   = W_IP + 1;
   localparam int W_SEL0   = W_LSEL + 1;
   localparam int W_GPR0   = W_SEL0 + NUM_SEGSEL;
   localparam int W_CACHE0 = W_GPR0 + NUM_GPR;
   localparam int W_GDT    = W_CACHE0 + NUM_CACHE * ENTRY_WORDS;
   localparam int W_IDT    = W_GDT + ENTRY_WORDS;
   localparam int TABLE_WORDS = W_IDT + ENTRY_WORDS;

   // Word index feeding selector slot s: segment slots, then local, then task.
   function automatic int sel_word(input int s);
      if (s < NUM_SEGSEL)       return W_SEL0 + s;
      else if (s == NUM_SEGSEL) return W_LSEL;
      else                      return W_TSEL;
   endfunction
endpackage

// File: rtl/srs_fetch_ctrl.sv
module srs_fetch_ctrl #(
   parameter int ADDR_W      = 24,
   parameter int TABLE_BASE  = 'h800,
   parameter int TABLE_WORDS = 51,
   localparam int IDX_W      = $clog2(TABLE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        cpl_i,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fault_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_WORDS - 1);

   if (TABLE_BASE % 2 != 0) begin : g_bad_align
      $error("table base must be word aligned");
   end
   if (TABLE_BASE + 2 * TABLE_WORDS > 2 ** ADDR_W) begin : g_bad_span
      $error("table does not fit the address space");
   end

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         idx_q   <= '0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         if (!busy_o) begin
            if (start_i) begin
               if (cpl_i == 2'd0) begin
                  busy_o <= 1'b1;
                  idx_q  <= '0;
               end else begin
                  fault_o <= 1'b1;
               end
            end
         end else if (ready_i) begin
            if (idx_q == LAST_IDX) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign wr_en_o = busy_o && ready_i;
   assign idx_o   = idx_q;
   assign addr_o  = ADDR_W'(TABLE_BASE) + ADDR_W'({idx_q, 1'b0});
endmodule

// File: rtl/srs_field_reg.sv
module srs_field_reg #(
   parameter int W     = 16,
   parameter int IDX_W = 6,
   parameter int MATCH = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [W-1:0]     data_i,
   output logic [W-1:0]     q_o
);
   if (MATCH >= 2 ** IDX_W) begin : g_bad_match
      $error("field index out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (wr_en_i && idx_i == IDX_W'(MATCH))
         q_o <= data_i;
   end
endmodule

// File: rtl/srs_entry_reg.sv
module srs_entry_reg #(
   parameter int IDX_W = 6,
   parameter int FIRST = 0,
   parameter int WORD_W = 16,
   parameter int BASE_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [BASE_W-1:0] base_o,
   output logic [WORD_W-1:0] lim_o
);
   localparam int HI_W = BASE_W - WORD_W;

   if (HI_W <= 0 || HI_W > WORD_W) begin : g_bad_width
      $error("base must span one to two words");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o <= '0;
         lim_o  <= '0;
      end else if (wr_en_i) begin
         if (idx_i == IDX_W'(FIRST))
            base_o[WORD_W-1:0] <= word_i;
         if (idx_i == IDX_W'(FIRST + 1))
            base_o[BASE_W-1:WORD_W] <= word_i[HI_W-1:0];
         if (idx_i == IDX_W'(FIRST + 2))
            lim_o <= word_i;
      end
   end
endmodule

// File: rtl/state_restore_seq.sv
module state_restore_seq
   import srs_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int TABLE_BASE = 'h800
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [1:0]                    cpl_i,
   output logic                          mem_req_o,
   output logic [ADDR_W-1:0]             mem_addr_o,
   input  logic                          mem_ready_i,
   input  logic [WORD_W-1:0]             mem_rdata_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic                          fault_o,
   output logic [WORD_W-1:0]             msw_o,
   output logic [WORD_W-1:0]             flags_o,
   output logic [WORD_W-1:0]             ip_o,
   output logic [NUM_GPR*WORD_W-1:0]     gpr_o,
   output logic [NUM_SEL*WORD_W-1:0]     sel_o,
   output logic [NUM_CACHE*BASE_W-1:0]   cache_base_o,
   output logic [NUM_CACHE*ACC_W-1:0]    cache_acc_o,
   output logic [NUM_CACHE*WORD_W-1:0]   cache_lim_o,
   output logic [BASE_W-1:0]             gdt_base_o,
   output logic [WORD_W-1:0]             gdt_lim_o,
   output logic [BASE_W-1:0]             idt_base_o,
   output logic [WORD_W-1:0]             idt_lim_o
);
   localparam int IDX_W = $clog2(TABLE_WORDS);

   if (ACC_W + (BASE_W - WORD_W) != WORD_W) begin : g_bad_pack
      $error("access byte and upper base must share one word");
   end

   logic             wr_en;
   logic [IDX_W-1:0] idx;

   srs_fetch_ctrl #(
      .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE), .TABLE_WORDS(TABLE_WORDS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpl_i(cpl_i),
      .ready_i(mem_ready_i), .busy_o(busy_o), .done_o(done_o),
      .fault_o(fault_o), .wr_en_o(wr_en), .idx_o(idx), .addr_o(mem_addr_o)
   );

   assign mem_req_o = busy_o;

   srs_field_reg #(.W(WORD_W), .IDX_W(IDX_W), .MATCH(W_MSW)) u_msw (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
      .data_i(mem_rdata_i), .q_o(msw_o));
   srs_field_reg #(.W(WORD_W), .IDX_W(IDX_W), .MATCH(W_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
      .data_i(mem_rdata_i), .q_o(flags_o));
   srs_field_reg #(.W(WORD_W), .IDX_W(IDX_W), .MATCH(W_IP)) u_ip (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
      .data_i(mem_rdata_i), .q_o(ip_o));

   for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
      srs_field_reg #(.W(WORD_W), .IDX_W(IDX_W), .MATCH(W_GPR0 + g)) u_r (
         .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
         .data_i(mem_rdata_i), .q_o(gpr_o[g*WORD_W +: WORD_W]));
   end

   for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
      srs_field_reg #(.W(WORD_W), .IDX_W(IDX_W), .MATCH(sel_word(s))) u_r (
         .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
         .data_i(mem_rdata_i), .q_o(sel_o[s*WORD_W +: WORD_W]));
   end

   for (genvar c = 0; c < NUM_CACHE; c++) begin : g_cache
      localparam int FIRST = W_CACHE0 + c * ENTRY_WORDS;
      srs_entry_reg #(.IDX_W(IDX_W), .FIRST(FIRST), .WORD_W(WORD_W), .BASE_W(BASE_W)) u_ent (
         .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
         .word_i(mem_rdata_i),
         .base_o(cache_base_o[c*BASE_W +: BASE_W]),
         .lim_o(cache_lim_o[c*WORD_W +: WORD_W]));
      srs_field_reg #(.W(ACC_W), .IDX_W(IDX_W), .MATCH(FIRST + 1)) u_acc (
         .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
         .data_i(mem_rdata_i[WORD_W-1 -: ACC_W]),
         .q_o(cache_acc_o[c*ACC_W +: ACC_W]));
   end

   srs_entry_reg #(.IDX_W(IDX_W), .FIRST(W_GDT), .WORD_W(WORD_W), .BASE_W(BASE_W)) u_gdt (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
      .word_i(mem_rdata_i), .base_o(gdt_base_o), .lim_o(gdt_lim_o));
   srs_entry_reg #(.IDX_W(IDX_W), .FIRST(W_IDT), .WORD_W(WORD_W), .BASE_W(BASE_W)) u_idt (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .idx_i(idx),
      .word_i(mem_rdata_i), .base_o(idt_base_o), .lim_o(idt_lim_o));
endmodule

// File: rtl/state_restore_seq_chk.sv
module state_restore_seq_chk #(
   parameter int ADDR_W     = 24,
   parameter int TABLE_BASE = 'h800,
   parameter int NWORDS     = 51,
   parameter int GPR_BITS   = 128,
   parameter int ACC_BITS   = 48
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [1:0]          cpl_i,
   input logic                mem_req_o,
   input logic [ADDR_W-1:0]   mem_addr_o,
   input logic                mem_ready_i,
   input logic                busy_o,
   input logic                done_o,
   input logic                fault_o,
   input logic [GPR_BITS-1:0] gpr_o,
   input logic [ACC_BITS-1:0] cache_acc_o
);
   localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(TABLE_BASE);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(TABLE_BASE + 2 * (NWORDS - 1));

   assert_start_priv_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(start_i) && $past(cpl_i) == 2'd0));

   assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o >= FIRST_A && mem_addr_o <= LAST_A && !mem_addr_o[0]));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ready_i && mem_addr_o != LAST_A) |=>
         (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(2)));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

   assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> ($past(start_i) && $past(cpl_i) != 2'd0 && !$past(busy_o)));

   assert_fault_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!mem_req_o && !busy_o));

   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !(mem_ready_i && mem_addr_o == LAST_A)) |=> busy_o);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o) && $past(mem_addr_o) == LAST_A));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> ($stable(gpr_o) && $stable(cache_acc_o)));
endmodule

bind state_restore_seq state_restore_seq_chk #(
   .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE), .NWORDS(srs_pkg::TABLE_WORDS),
   .GPR_BITS(srs_pkg::NUM_GPR * srs_pkg::WORD_W),
   .ACC_BITS(srs_pkg::NUM_CACHE * srs_pkg::ACC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpl_i(cpl_i),
   .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ready_i(mem_ready_i),
   .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
   .gpr_o(gpr_o), .cache_acc_o(cache_acc_o)
);

// File: tb/state_restore_seq_bench.sv
`timescale 1ns/1ps
module state_restore_seq_bench;
   localparam int NW = 51;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] cpl = 2'd0;
   logic mem_req, mem_ready, busy, done, fault;
   logic [23:0] mem_addr;
   logic [15:0] mem_rdata, msw, flags, ip, gdt_lim, idt_lim;
   logic [127:0] gpr;
   logic [95:0] sel, cache_lim;
   logic [143:0] cache_base;
   logic [47:0] cache_acc;
   logic [23:0] gdt_base, idt_base;

   logic [15:0] mem [NW];
   logic [15:0] exp_w [NW];
   int ws = 0;
   int wcnt = 0;
   int xfers = 0;
   int addr_err = 0;
   int cycles = 0;
   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   state_restore_seq u_state_restore_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cpl_i(cpl),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
      .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .fault_o(fault),
      .msw_o(msw), .flags_o(flags), .ip_o(ip), .gpr_o(gpr), .sel_o(sel),
      .cache_base_o(cache_base), .cache_acc_o(cache_acc), .cache_lim_o(cache_lim),
      .gdt_base_o(gdt_base), .gdt_lim_o(gdt_lim), .idt_base_o(idt_base),
      .idt_lim_o(idt_lim));

   // Memory model with a programmable number of wait states per word
   assign mem_ready = mem_req && (wcnt >= ws);
   always_comb begin
      int k;
      k = (int'(mem_addr) - 'h800) / 2;
      mem_rdata = (k >= 0 && k < NW) ? mem[k] : 16'hDEAD;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!mem_req || mem_ready) wcnt <= 0;
      else wcnt <= wcnt + 1;
      if (rst_n && mem_req && mem_ready) begin
         if (int'(mem_addr) != 'h800 + 2 * (xfers % NW)) addr_err <= addr_err + 1;
         xfers <= xfers + 1;
      end
   end

   initial begin
      wait (cycles > 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int seed);
      for (int k = 0; k < NW; k++) mem[k] = 16'(k * 'h0123 + seed * 'h0B5D) ^ 16'h5A5A;
   endtask

   // Compare every decoded field with the layout of R4 / R5
   task automatic check_fields(input string req);
      chk(req, "msw", 64'(msw), 64'(exp_w[0]));
      chk(req, "task sel", 64'(sel[5*16 +: 16]), 64'(exp_w[11]));
      chk(req, "flags", 64'(flags), 64'(exp_w[12]));
      chk(req, "ip", 64'(ip), 64'(exp_w[13]));
      chk(req, "local sel", 64'(sel[4*16 +: 16]), 64'(exp_w[14]));
      for (int s = 0; s < 4; s++)
         chk(req, $sformatf("sel%0d", s), 64'(sel[s*16 +: 16]), 64'(exp_w[15+s]));
      for (int g = 0; g < 8; g++)
         chk(req, $sformatf("gpr%0d", g), 64'(gpr[g*16 +: 16]), 64'(exp_w[19+g]));
      for (int c = 0; c < 6; c++) begin
         int f = 27 + 3 * c;
         chk(req, $sformatf("cache%0d base", c), 64'(cache_base[c*24 +: 24]),
             64'({exp_w[f+1][7:0], exp_w[f]}));
         chk(req, $sformatf("cache%0d acc", c), 64'(cache_acc[c*8 +: 8]), 64'(exp_w[f+1][15:8]));
         chk(req, $sformatf("cache%0d lim", c), 64'(cache_lim[c*16 +: 16]), 64'(exp_w[f+2]));
      end
      chk(req, "gdt base", 64'(gdt_base), 64'({exp_w[46][7:0], exp_w[45]}));
      chk(req, "gdt lim", 64'(gdt_lim), 64'(exp_w[47]));
      chk(req, "idt base", 64'(idt_base), 64'({exp_w[49][7:0], exp_w[48]}));
      chk(req, "idt lim", 64'(idt_lim), 64'(exp_w[50]));
   endtask

   // Start a restore, optionally pulse start again mid-run; return busy cycles
   task automatic run_restore(input int wait_states, input int restart_at, output int nbusy);
      int x0;
      ws = wait_states;
      x0 = xfers;
      nbusy = 0;
      for (int k = 0; k < NW; k++) exp_w[k] = mem[k];
      cpl = 2'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 5000; t++) begin
         if (done) break;
         if (busy) nbusy++;
         start = (nbusy == restart_at);
         @(negedge clk);
      end
      start = 1'b0;
      chk("R9", "done at end", 64'(done), 64'd1);
      chk("R9", "busy low with done", 64'(busy), 64'd0);
      chk("R2", "reads per run", 64'(xfers - x0), 64'(NW));
      chk("R2", "address order errors", 64'(addr_err), 64'd0);
      @(negedge clk);
      chk("R9", "done one cycle", 64'(done), 64'd0);
   endtask

   task automatic t_reset();
      chk("R10", "busy after reset", 64'(busy), 64'd0);
      chk("R10", "done after reset", 64'(done), 64'd0);
      chk("R10", "fault after reset", 64'(fault), 64'd0);
      chk("R10", "req after reset", 64'(mem_req), 64'd0);
      chk("R10", "gpr after reset", 64'(gpr[63:0]), 64'd0);
      chk("R10", "cache base after reset", 64'(cache_base[63:0]), 64'd0);
   endtask

   task automatic t_basic();
      int n;
      fill(1);
      run_restore(0, -1, n);
      chk("R1", "busy cycles no wait", 64'(n), 64'(NW));
      check_fields("R4");
   endtask

   task automatic t_wait();
      int n;
      fill(2);
      run_restore(2, -1, n);
      chk("R3", "busy cycles two waits", 64'(n), 64'(NW * 3));
      check_fields("R5");
   endtask

   task automatic t_fault();
      int reqs = 0;
      fill(3);
      cpl = 2'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7", "fault pulse", 64'(fault), 64'd1);
      chk("R7", "busy on fault", 64'(busy), 64'd0);
      for (int t = 0; t < 6; t++) begin
         @(negedge clk);
         if (mem_req) reqs++;
         if (t == 0) chk("R7", "fault one cycle", 64'(fault), 64'd0);
      end
      chk("R7", "requests after refusal", 64'(reqs), 64'd0);
      cpl = 2'd0;
      check_fields("R10");
   endtask

   task automatic t_busy_start();
      int n;
      int reqs = 0;
      fill(4);
      run_restore(1, 20, n);
      chk("R8", "busy cycles with restart", 64'(n), 64'(NW * 2));
      for (int t = 0; t < 6; t++) begin
         @(negedge clk);
         if (busy) reqs++;
      end
      chk("R8", "no second run", 64'(reqs), 64'd0);
      check_fields("R8");
   endtask

   task automatic t_raw();
      int n;
      fill(5);
      for (int c = 0; c < 6; c++) begin
         mem[28 + 3*c][15:8] = (c % 2 == 0) ? 8'h00 : 8'hFF;
         mem[29 + 3*c] = 16'h0000;
      end
      for (int s = 0; s < 4; s++) mem[15 + s] = 16'hFFFF - 16'(s);
      run_restore(0, -1, n);
      chk("R6", "not-present access byte kept", 64'(cache_acc[7:0]), 64'h00);
      chk("R6", "odd access byte kept", 64'(cache_acc[15:8]), 64'hFF);
      chk("R6", "zero limit kept", 64'(cache_lim[15:0]), 64'h0);
      check_fields("R6");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_wait();
      t_fault();
      t_busy_start();
      t_raw();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule